// File: doc/BRIEF.md
# Cascaded Priority Encoder (32 requests, highest wins)

This block reports which of 32 request lines has the highest number among those that are asserted. It is built from four identical 8-input encoder slices. Each slice gives a 3-bit position and two flags. The "hit" flag means the slice is enabled and sees a request. The "idle" flag means the slice is enabled and sees none. The slices are chained from the top group down: a slice's idle flag is the enable of the slice for the next-lower group. A request in a higher group therefore disables every group below it.

The merged result is a 5-bit index, an overall hit flag and an overall idle flag. The idle flag tells "no request" apart from "request on line 0", which both give index 0. The block is purely combinational, so results follow the inputs in the same cycle. It has no data stream, so no valid/ready handshake applies: every pin is plain control or status.

Top module: `prio_cascade`

## Requirements
- R1: When `en_i` is 1 and at least one request is set, `idx_o` equals the number of the highest-numbered set bit of `req_i`.
- R2: `hit_o` is 1 exactly when `en_i` is 1 and `req_i` is non-zero.
- R3: `idle_o` is 1 exactly when `en_i` is 1 and `req_i` is zero.
- R4: When `en_i` is 0, `idx_o`, `hit_o` and `idle_o` are all 0, whatever `req_i` holds.
- R5: With `en_i` at 1 and `req_i` at zero, the outputs are `idx_o`=0, `hit_o`=0 and `idle_o`=1. A lone request on line 0 instead gives `idx_o`=0, `hit_o`=1 and `idle_o`=0.
- R6: A request in a higher 8-bit group masks every request in the lower groups. At most one slice reports a hit at any time.
- R7: `idx_o[4:3]` is the group number (3 for lines 31..24, down to 0 for lines 7..0). `idx_o[2:0]` is the position of the winning line inside that group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_i | input | 1 | Global enable, fed to the top slice |
| req_i | input | 32 | Request lines; line 31 has the highest priority |
| idx_o | output | 5 | Number of the winning request line |
| hit_o | output | 1 | Enabled and at least one request present |
| idle_o | output | 1 | Enabled and no request present |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with no register in the path. The bench changes the inputs just after a falling clock edge and samples all three outputs one nanosecond later, well before the next rising edge. Each sample is compared against a behavioural highest-set-bit function. Directed vectors cover every single-hot pattern, the all-zero and disabled cases, and group-masking cases. Seeded random multi-hot vectors follow, including sparse ones that exercise each group boundary.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned SLICE_W    = 8;
  localparam int unsigned NUM_SLICES = 4;
  localparam int unsigned POS_W      = $clog2(SLICE_W);
  localparam int unsigned GRP_W      = $clog2(NUM_SLICES);
  localparam int unsigned TOTAL_W    = SLICE_W * NUM_SLICES;
  localparam int unsigned INDEX_W    = POS_W + GRP_W;
endpackage

// File: rtl/prio_slice.sv
module prio_slice #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = $clog2(WIDTH)
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] req_i,
  output logic [PW-1:0]    pos_o,
  output logic             hit_o,
  output logic             idle_o
);
  logic [PW-1:0] scan_pos;
  logic          any_req;

  always_comb begin
    scan_pos = '0;
    for (int i = 0; i < int'(WIDTH); i++) begin
      if (req_i[i]) scan_pos = PW'(i);
    end
  end

  assign any_req = |req_i;
  assign pos_o   = en_i ? scan_pos : '0;
  assign hit_o   = en_i & any_req;
  assign idle_o  = en_i & ~any_req;

  always_comb begin
    if (!en_i) AST_SLICE_QUIET: assert (pos_o == '0 && !hit_o && !idle_o); // R4
    AST_SLICE_EXCL: assert (!(hit_o && idle_o)); // R2
    if (hit_o) AST_SLICE_TOP: assert ((req_i >> pos_o) == WIDTH'(1)); // R1
  end
endmodule

// File: rtl/prio_merge.sv
module prio_merge #(
  parameter int unsigned NS = 4,
  parameter int unsigned PW = 3,
  localparam int unsigned GW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic [NS-1:0][PW-1:0] pos_i,
  input  logic [NS-1:0]         hit_i,
  output logic [GW+PW-1:0]      idx_o,
  output logic                  hit_o
);
  logic [PW-1:0] low_bits;
  logic [GW-1:0] grp_bits;

  always_comb begin
    low_bits = '0;
    grp_bits = '0;
    for (int s = 0; s < int'(NS); s++) begin
      low_bits = low_bits | pos_i[s];
      if (hit_i[s]) grp_bits = grp_bits | GW'(s);
    end
  end

  assign idx_o = {grp_bits, low_bits};
  assign hit_o = |hit_i;

  always_comb begin
    AST_ONE_GROUP: assert ($onehot0(hit_i)); // R6
  end
endmodule

// File: rtl/prio_cascade.sv
module prio_cascade
  import prio_pkg::*;
(
  input  logic               en_i,
  input  logic [TOTAL_W-1:0] req_i,
  output logic [INDEX_W-1:0] idx_o,
  output logic               hit_o,
  output logic               idle_o
);
  logic [NUM_SLICES-1:0][POS_W-1:0] sl_pos;
  logic [NUM_SLICES-1:0]            sl_hit;
  logic [NUM_SLICES-1:0]            sl_idle;
  logic [NUM_SLICES-1:0]            sl_en;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    if (s == NUM_SLICES - 1) begin : g_top
      assign sl_en[s] = en_i;
    end else begin : g_chain
      assign sl_en[s] = sl_idle[s+1];
    end

    prio_slice #(.WIDTH(SLICE_W)) u_slice (
      .en_i  (sl_en[s]),
      .req_i (req_i[s*SLICE_W +: SLICE_W]),
      .pos_o (sl_pos[s]),
      .hit_o (sl_hit[s]),
      .idle_o(sl_idle[s])
    );
  end

  prio_merge #(.NS(NUM_SLICES), .PW(POS_W)) u_merge (
    .pos_i(sl_pos),
    .hit_i(sl_hit),
    .idx_o(idx_o),
    .hit_o(hit_o)
  );

  assign idle_o = sl_idle[0];

  always_comb begin
    if (hit_o) AST_WINNER_TOP: assert ((req_i >> idx_o) == TOTAL_W'(1)); // R1
    AST_HIT_MATCH: assert (hit_o == (en_i && req_i != '0)); // R2
    AST_IDLE_MATCH: assert (idle_o == (en_i && req_i == '0)); // R3
    if (!en_i) AST_OFF_ZERO: assert (idx_o == '0 && !hit_o && !idle_o); // R4
    if (idle_o) AST_IDLE_IDX: assert (idx_o == '0); // R5
  end
endmodule

// File: tb/sim_prio_cascade.sv
module sim_prio_cascade;
  logic        clk = 1'b0;
  logic        en;
  logic [31:0] req;
  logic [4:0]  idx;
  logic        hit, idle;
  int n_chk = 0, n_bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  prio_cascade u0 (.en_i(en), .req_i(req), .idx_o(idx), .hit_o(hit), .idle_o(idle));

  function automatic logic [6:0] model(input logic e, input logic [31:0] r);
    logic [4:0] k = '0;
    for (int i = 0; i < 32; i++) if (r[i]) k = 5'(i);
    if (!e) return 7'b0;
    if (r == 0) return {5'd0, 1'b0, 1'b1};
    return {k, 1'b1, 1'b0};
  endfunction

  task automatic apply(input logic e, input logic [31:0] r, input string tag);
    logic [6:0] exp;
    @(negedge clk);
    en = e; req = r;
    #1;
    exp = model(e, r);
    n_chk++;
    if ({idx, hit, idle} !== exp) begin
      n_bad++;
      $display("FAIL %s en=%0b req=%h got idx=%0d hit=%0b idle=%0b exp idx=%0d hit=%0b idle=%0b",
               tag, e, r, idx, hit, idle, exp[6:2], exp[1], exp[0]);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_1234));
    en = 1'b0; req = '0;
    apply(1'b0, 32'h0, "R4 initial disabled state");
    apply(1'b1, 32'h0, "R5 R3 enabled no request");
    apply(1'b1, 32'h1, "R5 R2 lone request on line 0");
    for (int i = 0; i < 32; i++) apply(1'b1, 32'h1 << i, "R1 R7 single-hot");
    apply(1'b0, 32'hffff_ffff, "R4 disabled all set");
    apply(1'b0, 32'h8000_0001, "R4 disabled sparse");
    apply(1'b1, 32'hffff_ffff, "R1 all set");
    apply(1'b1, 32'h0100_00ff, "R6 group 3 masks lower");
    apply(1'b1, 32'h0001_ff00, "R6 group 2 masks group 1");
    apply(1'b1, 32'h0000_0180, "R6 R7 group boundary 8/7");
    apply(1'b1, 32'h00ff_0001, "R6 R7 group 2 top line");
    for (int n = 0; n < 400; n++) begin
      r = $urandom();
      if (n % 3 == 1) r = r & $urandom() & $urandom();
      if (n % 3 == 2) r = r >> ($urandom() % 32);
      apply((n % 17) != 0, r, "R1 R2 R3 R6 R7 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule